// File: doc/BRIEF.md
# Mode-Switched Data-Bus Port Multiplexer

This block owns one eight-pin group and gives it a role that depends on a two-bit operating mode. In single-chip mode the pins form a general-purpose port. A latch register sets the output values and a direction register picks, pin by pin, between driving and a high-impedance input. In the expanded modes the pins become part of the external data bus. With a wide bus they carry the upper byte of each 16-bit transfer. With a narrow bus they carry the high byte and then the low byte on two successive cycles. In a visibility mode, an internal 16-bit access is shown in a single cycle: the upper byte goes on this port and the lower byte on a companion port.

The mode input is registered once, and both the pin behaviour and the register map follow the registered copy. The two port registers are visible on a small register bus only in single-chip mode. Their contents survive trips through the other modes. Transfer requests come from an internal access interface. Each request carries a 16-bit word and a flag that marks it as an external access or an internal one. The outputs are pin values and per-pin output enables for both ports, plus a busy flag.

Top module: `busport_mux`

## Requirements
- R1: After reset, both port registers hold 0x00, every output enable on both ports is 0, and busy is 0.
- R2: With the registered mode single-chip (mode code 0), a write to offset 0x4 sets the latch register and a write to offset 0x6 sets the direction register. From the cycle after the write, pc_out shows the latch and pc_oe shows the direction bits (1 = driven, 0 = high-impedance input).
- R3: In single-chip mode, reading offset 0x4 returns, for each bit, the latch bit where the direction bit is 1 and the pin level sampled on the previous clock where it is 0. Reading offset 0x6 returns the direction register.
- R4: In modes 1, 2 and 3, both registers are outside the map. Reads return 0x00 and writes change nothing, and the stored values are seen again after a return to mode 0.
- R5: Offsets other than 0x4 and 0x6 read as 0x00, and writes to them change no register.
- R6: In wide mode (code 1), an external request accepted while idle drives pc_out with acc_data[15:8] and sets pc_oe to 0xFF, with busy at 1, for exactly the next cycle. Internal requests do nothing in this mode.
- R7: In narrow mode (code 2), an accepted external request gives two busy cycles. The first drives acc_data[15:8] and the second drives acc_data[7:0], both with pc_oe at 0xFF. After that the port is idle with busy at 0.
- R8: In visibility mode (code 3), an accepted internal request gives one busy cycle with pc_out = acc_data[15:8], pd_out = acc_data[7:0] and both enables at 0xFF. An external request is split exactly as in R7, with pd_oe kept at 0.
- R9: Requests arriving while busy is 1 are dropped, and so are all requests in single-chip mode.
- R10: A change on the mode input reaches the pins and the register map one clock later.
- R11: Whenever no transfer is active and the registered mode is not single-chip, pc_oe and pd_oe are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode: 0 single-chip, 1 wide, 2 narrow, 3 visibility |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pc_in | input | 8 | Port pin levels |
| acc_req | input | 1 | Transfer request |
| acc_ext | input | 1 | 1 = external access, 0 = internal access |
| acc_data | input | 16 | Transfer word |
| pc_out | output | 8 | Port pin output values |
| pc_oe | output | 8 | Port pin output enables |
| pd_out | output | 8 | Companion port output values |
| pd_oe | output | 8 | Companion port output enables |
| busy | output | 1 | A transfer beat is on the pins |

## Verification
The bench checks the byte order of split transfers: a design that swaps the beats, or stops after one, shows the wrong byte in the first or second cycle. It checks the read value of a mixed-direction port, where a design that returns only the latch or only the pins fails on half the bits. It writes registers while they are out of the map and then returns to single-chip mode, which catches a design that lets those writes through or clears the registers on a mode change. It also holds a request through a whole split transfer and checks the cycle after the mode input changes, so a design that restarts mid-transfer or reacts to mode without the one-clock delay shows the wrong byte or the wrong enables.

// File: rtl/busport_pkg.sv
package busport_pkg;
  localparam int PORT_W = 8;
  localparam int BUS_W  = 2 * PORT_W;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_WIDE   = 2'd1,
    MD_NARROW = 2'd2,
    MD_VISIB  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_ONE  = 2'd1,
    BT_HI   = 2'd2,
    BT_LO   = 2'd3
  } beat_e;

  // direction bit 1 -> latched value, 0 -> sampled pin
  function automatic logic [PORT_W-1:0] merge_read(input logic [PORT_W-1:0] dir,
                                                   input logic [PORT_W-1:0] lat,
                                                   input logic [PORT_W-1:0] pin);
    return (dir & lat) | (~dir & pin);
  endfunction

  function automatic logic [PORT_W-1:0] upper_half(input logic [BUS_W-1:0] w);
    return w[BUS_W-1:PORT_W];
  endfunction

  function automatic logic [PORT_W-1:0] lower_half(input logic [BUS_W-1:0] w);
    return w[PORT_W-1:0];
  endfunction
endpackage

// File: rtl/busport_regs.sv
module busport_regs
  import busport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_DATA = 4,
  parameter int OFF_DIR  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] reg_rdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] ddr_q,
  output logic              wr_data,
  output logic              wr_dir
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);

  logic [PORT_W-1:0] pin_q;
  logic              hit_data, hit_dir;

  assign hit_data = map_en && (reg_addr == A_DATA);
  assign hit_dir  = map_en && (reg_addr == A_DIR);
  assign wr_data  = reg_wr && hit_data;
  assign wr_dir   = reg_wr && hit_dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ddr_q  <= '0;
      pin_q  <= '0;
    end else begin
      pin_q <= pc_in;
      if (wr_data) data_q <= reg_wdata;
      if (wr_dir)  ddr_q  <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_data)     reg_rdata = merge_read(ddr_q, data_q, pin_q);
    else if (hit_dir) reg_rdata = ddr_q;
  end
endmodule

// File: rtl/busport_seq.sv
module busport_seq
  import busport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode_q,
  input  logic             acc_req,
  input  logic             acc_ext,
  input  logic [BUS_W-1:0] acc_data,
  output beat_e            beat,
  output logic [PORT_W-1:0] hi_q,
  output logic [PORT_W-1:0] lo_q,
  output logic             vis_q,
  output logic             start_one,
  output logic             start_vis,
  output logic             start_split,
  output logic             busy
);
  logic idle, start_wide;

  assign idle        = (beat == BT_IDLE);
  assign start_wide  = idle && acc_req && acc_ext && (mode_q == MD_WIDE);
  assign start_vis   = idle && acc_req && !acc_ext && (mode_q == MD_VISIB);
  assign start_split = idle && acc_req && acc_ext &&
                       ((mode_q == MD_NARROW) || (mode_q == MD_VISIB));
  assign start_one   = start_wide || start_vis;
  assign busy        = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat  <= BT_IDLE;
      hi_q  <= '0;
      lo_q  <= '0;
      vis_q <= 1'b0;
    end else begin
      case (beat)
        BT_IDLE: begin
          if (start_one || start_split) begin
            hi_q  <= upper_half(acc_data);
            lo_q  <= lower_half(acc_data);
            vis_q <= start_vis;
            beat  <= start_split ? BT_HI : BT_ONE;
          end
        end
        BT_HI:   beat <= BT_LO;
        default: beat <= BT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/busport_drive.sv
module busport_drive
  import busport_pkg::*;
(
  input  mode_e             mode_q,
  input  beat_e             beat,
  input  logic [PORT_W-1:0] hi_q,
  input  logic [PORT_W-1:0] lo_q,
  input  logic              vis_q,
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] ddr_q,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe,
  output logic [PORT_W-1:0] pd_out,
  output logic [PORT_W-1:0] pd_oe
);
  always_comb begin
    pc_out = '0;
    pc_oe  = '0;
    pd_out = '0;
    pd_oe  = '0;
    case (beat)
      BT_ONE: begin
        pc_out = hi_q;
        pc_oe  = '1;
        if (vis_q) begin
          pd_out = lo_q;
          pd_oe  = '1;
        end
      end
      BT_HI: begin
        pc_out = hi_q;
        pc_oe  = '1;
      end
      BT_LO: begin
        pc_out = lo_q;
        pc_oe  = '1;
      end
      default: begin
        if (mode_q == MD_SINGLE) begin
          pc_out = data_q;
          pc_oe  = ddr_q;
        end
      end
    endcase
  end
endmodule

// File: rtl/busport_mux.sv
module busport_mux
  import busport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_DATA = 4,
  parameter int OFF_DIR  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] pc_in,
  input  logic              acc_req,
  input  logic              acc_ext,
  input  logic [BUS_W-1:0]  acc_data,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe,
  output logic [PORT_W-1:0] pd_out,
  output logic [PORT_W-1:0] pd_oe,
  output logic              busy
);
  mode_e             mode_q;
  logic              map_en;
  logic [PORT_W-1:0] data_q, ddr_q, hi_q, lo_q;
  logic              wr_data, wr_dir, vis_q;
  logic              start_one, start_vis, start_split;
  beat_e             beat;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MD_SINGLE;
    else        mode_q <= mode_e'(mode);
  end

  assign map_en = (mode_q == MD_SINGLE);

  busport_regs #(.ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pc_in(pc_in),
    .reg_rdata(reg_rdata), .data_q(data_q), .ddr_q(ddr_q),
    .wr_data(wr_data), .wr_dir(wr_dir)
  );

  busport_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .acc_req(acc_req),
    .acc_ext(acc_ext), .acc_data(acc_data), .beat(beat), .hi_q(hi_q),
    .lo_q(lo_q), .vis_q(vis_q), .start_one(start_one), .start_vis(start_vis),
    .start_split(start_split), .busy(busy)
  );

  busport_drive u_drive (
    .mode_q(mode_q), .beat(beat), .hi_q(hi_q), .lo_q(lo_q), .vis_q(vis_q),
    .data_q(data_q), .ddr_q(ddr_q), .pc_out(pc_out), .pc_oe(pc_oe),
    .pd_out(pd_out), .pd_oe(pd_oe)
  );
endmodule

// File: rtl/busport_chk.sv
module busport_chk
  import busport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input mode_e             mode_q,
  input logic              reg_wr,
  input logic [PORT_W-1:0] reg_wdata,
  input logic              map_en,
  input logic              wr_dir,
  input logic [PORT_W-1:0] data_q,
  input logic [PORT_W-1:0] ddr_q,
  input logic [BUS_W-1:0]  acc_data,
  input logic              start_one,
  input logic              start_vis,
  input logic              start_split,
  input logic              busy,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe,
  input logic [PORT_W-1:0] pd_out,
  input logic [PORT_W-1:0] pd_oe
);
  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && mode == MD_SINGLE && !busy) |=> pc_oe == $past(reg_wdata));

  // R4
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !map_en) |=> ($stable(data_q) && $stable(ddr_q)));

  // R6
  wide_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_one && !start_vis) |=>
      (busy && pc_oe == '1 && pc_out == upper_half($past(acc_data))) ##1 !busy);

  // R7
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_split |=> (busy && pc_out == upper_half($past(acc_data)))
      ##1 (busy && pc_out == lower_half($past(acc_data, 2))) ##1 !busy);

  // R8
  visib_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vis |=> (pd_oe == '1 && pd_out == lower_half($past(acc_data)) &&
                   pc_out == upper_half($past(acc_data))));

  // R11
  quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_q != MD_SINGLE) |-> (pc_oe == '0 && pd_oe == '0));
endmodule

bind busport_mux busport_chk chk (.*);

// File: tb/busport_mux_test.sv
`timescale 1ns/1ps
module busport_mux_test;
  import busport_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  pc_in = '0;
  logic        acc_req = 1'b0;
  logic        acc_ext = 1'b0;
  logic [15:0] acc_data = '0;
  logic [7:0]  pc_out, pc_oe, pd_out, pd_oe;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  busport_mux uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_in(pc_in),
    .acc_req(acc_req), .acc_ext(acc_ext), .acc_data(acc_data),
    .pc_out(pc_out), .pc_oe(pc_oe), .pd_out(pd_out), .pd_oe(pd_oe), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] mix_expect(input logic [7:0] d, l, p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[i] ? l[i] : p[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    step();
  endtask

  task automatic t_reset();
    check("R1 pc_oe", {8'h00, pc_oe}, 16'h0);
    check("R1 pd_oe", {8'h00, pd_oe}, 16'h0);
    check("R1 busy", {15'h0, busy}, 16'h0);
    rd_chk("R1 dir reg", 4'h6, 8'h00);
    rd_chk("R1 data reg", 4'h4, 8'h00);
  endtask

  task automatic t_gpio();
    wr_reg(4'h6, 8'hF0);
    check("R2 pc_oe after dir write", {8'h00, pc_oe}, 16'h00F0);
    wr_reg(4'h4, 8'hA5);
    check("R2 pc_out after data write", {8'h00, pc_out}, 16'h00A5);
    rd_chk("R3 dir readback", 4'h6, 8'hF0);
  endtask

  task automatic t_readmix();
    wr_reg(4'h6, 8'h0F);
    pc_in = 8'h3C;
    step();
    rd_chk("R3 mixed read a", 4'h4, mix_expect(8'h0F, 8'hA5, 8'h3C));
    pc_in = 8'hC3;
    step();
    rd_chk("R3 mixed read b", 4'h4, mix_expect(8'h0F, 8'hA5, 8'hC3));
  endtask

  task automatic t_offset();
    wr_reg(4'h5, 8'hFF);
    wr_reg(4'h0, 8'hFF);
    rd_chk("R5 unmapped read", 4'h5, 8'h00);
    rd_chk("R5 dir intact", 4'h6, 8'h0F);
    rd_chk("R5 data intact", 4'h4, mix_expect(8'h0F, 8'hA5, 8'hC3));
  endtask

  task automatic t_mode_change();
    mode = 2'd1;
    #1;
    check("R10 oe before edge", {8'h00, pc_oe}, 16'h000F);
    step();
    check("R10 oe after edge", {8'h00, pc_oe}, 16'h0000);
    check("R11 idle pd_oe", {8'h00, pd_oe}, 16'h0000);
    rd_chk("R4 unmapped dir read", 4'h6, 8'h00);
    wr_reg(4'h6, 8'hFF);
    wr_reg(4'h4, 8'h00);
    set_mode(2'd0);
    rd_chk("R4 dir preserved", 4'h6, 8'h0F);
    check("R4 pins restored", {pc_oe, pc_out}, 16'h0FA5);
  endtask

  task automatic t_wide();
    set_mode(2'd1);
    acc_req = 1'b1; acc_ext = 1'b0; acc_data = 16'h1234;
    step();
    acc_req = 1'b0;
    check("R6 internal ignored", {7'h0, busy, pc_oe}, 16'h0000);
    step();
    acc_req = 1'b1; acc_ext = 1'b1; acc_data = 16'hA5C3;
    step();
    acc_req = 1'b0;
    check("R6 wide beat", {pc_oe, pc_out}, 16'hFFA5);
    check("R6 wide busy", {7'h0, busy, pd_oe}, 16'h0100);
    step();
    check("R6 wide ends", {7'h0, busy, pc_oe}, 16'h0000);
  endtask

  task automatic t_narrow();
    set_mode(2'd2);
    acc_req = 1'b1; acc_ext = 1'b1; acc_data = 16'hBEEF;
    step();
    acc_req = 1'b0;
    check("R7 first beat high", {7'h0, busy, pc_out}, 16'h01BE);
    step();
    check("R7 second beat low", {7'h0, busy, pc_out}, 16'h01EF);
    check("R7 second beat oe", {8'h00, pc_oe}, 16'h00FF);
    step();
    check("R7 split ends", {7'h0, busy, pc_oe}, 16'h0000);
  endtask

  task automatic t_busy();
    acc_req = 1'b1; acc_ext = 1'b1; acc_data = 16'h1357;
    step();
    check("R9 held req first", {7'h0, busy, pc_out}, 16'h0113);
    acc_data = 16'h2468;
    step();
    check("R9 held req second", {7'h0, busy, pc_out}, 16'h0157);
    step();
    check("R9 request during busy dropped", {7'h0, busy, pc_oe}, 16'h0000);
    acc_req = 1'b0;
    set_mode(2'd0);
    acc_req = 1'b1;
    step();
    acc_req = 1'b0;
    check("R9 single mode request dropped", {7'h0, busy, pc_oe}, 16'h000F);
  endtask

  task automatic t_visib();
    set_mode(2'd3);
    acc_req = 1'b1; acc_ext = 1'b0; acc_data = 16'hC0DE;
    step();
    acc_req = 1'b0;
    check("R8 visibility bytes", {pc_out, pd_out}, 16'hC0DE);
    check("R8 visibility enables", {pc_oe, pd_oe}, 16'hFFFF);
    check("R8 visibility busy", {15'h0, busy}, 16'h0001);
    step();
    check("R8 visibility ends", {7'h0, busy, pd_oe}, 16'h0000);
    acc_req = 1'b1; acc_ext = 1'b1; acc_data = 16'hF00D;
    step();
    acc_req = 1'b0;
    check("R8 external high beat", {pd_oe, pc_out}, 16'h00F0);
    step();
    check("R8 external low beat", {pd_oe, pc_out}, 16'h000D);
    step();
    check("R11 visibility idle", {pc_oe, pd_oe}, 16'h0000);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_gpio();
    t_readmix();
    t_offset();
    t_mode_change();
    t_wide();
    t_narrow();
    t_busy();
    t_visib();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule